// File: doc/BRIEF.md
# Received-Word Bit Monitor

This block watches a stream of 32-bit avionics serial words handed over by up to eight receive channels, and drives a small set of monitor output pins. Each pin watches one payload bit of one message. It selects that message by a receive channel and an 8-bit label, and it selects the bit by its position in the word. Each time a word arrives on an enabled channel and carries the label a pin is looking for, the pin takes the value of its chosen bit and holds it until the next such word. External logic can therefore follow selected payload bits without reading the receive buffers.

A byte-wide register port configures the pins. Each pin has a selector byte that holds the channel number and the bit position, and a label byte. A shared status byte always reads back the current pin levels, and a host write to it loads all pins at once. The parameter `NUM_PINS` chooses the full eight-pin build or a reduced build. In the reduced build, register addresses of pins that are not built are dead.

Top module: `rx_bit_monitor`

## Requirements
- R1: While `rst_n` is low, every pin, every selector byte and every label byte is zero, and the status byte reads zero.
- R2: A word presented with `rx_valid` high changes pin p in the cycle after it arrives when all of these hold: its channel equals the channel field of pin p, that channel's `rx_en` bit is 1, `rx_word[7:0]` equals the label byte of pin p, and the bit field selects a position from 8 to 31. Pin p then equals `rx_word[position]`. In every other cycle the pin keeps its value.
- R3: A bit field value from 0 to 7 never changes the pin, even when the channel and label match.
- R4: A word from a channel whose `rx_en` bit is 0 changes no pin.
- R5: The label is compared with `rx_word[7:0]` exactly as the bits stand, with no bit reversal. A word with a different label, or from a different channel, leaves the pin unchanged.
- R6: One word that matches several pins updates all of them in the same cycle.
- R7: Address 0x805F is the status byte. Reading it returns the pin levels in bits NUM_PINS-1:0 and zeros above them. Writing it loads the pins from `reg_wdata` in the next cycle.
- R8: When a status write and a matching word reach the same pin in the same cycle, the value from the word wins. The other pins take the written value.
- R9: Pin p has its selector byte at 0x8060+2p, with the channel in bits 7:5 and the bit position in bits 4:0. Its label byte is at 0x8061+2p. Both read back as written.
- R10: In a reduced build, writes to the pin addresses of pins that are not built have no effect. Those addresses read zero, and so does any address outside the map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| rx_en | input | NUM_CH | Per-channel receiver enable |
| rx_valid | input | 1 | Received word strobe, one cycle per word |
| rx_chan | input | 3 | Channel that delivered the word |
| rx_word | input | 32 | Received word, label in bits 7:0 |
| reg_addr | input | 16 | Register address (read and write) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| mon_pin | output | NUM_PINS | Monitor pin levels |

## Verification
The bound assertions check on every cycle that the pins are cleared during reset and hold when no word and no write arrive. They also check that a word from a disabled channel never moves a pin, that a status write with no word loads the written value, that the status byte always mirrors the pins, and that dead addresses read zero. The bench's scenarios must show the matching itself. They cover the exact channel, label and bit selection, label values that are not bit palindromes, bit positions below 8 that fall inside the label field, several pins updating together, and the priority between a word and a write in the same cycle. The bench also runs a full and a reduced build side by side to compare the dead address range.

// File: rtl/arxm_pkg.sv
package arxm_pkg;
  localparam int WORD_W        = 32;
  localparam int LABEL_W       = 8;
  localparam int CHAN_W        = 3;
  localparam int BITSEL_W      = 5;
  localparam int ADDR_W        = 16;
  localparam int DATA_W        = 8;
  localparam int MAX_PINS      = 8;
  localparam int FIRST_MON_BIT = 8;   // lower positions overlap the label field

  localparam logic [ADDR_W-1:0] STATUS_ADDR   = 16'h805F;
  localparam logic [ADDR_W-1:0] CFG_BASE_ADDR = 16'h8060;

  // Per-pin configuration; selector byte is {chan, bitpos}.
  typedef struct packed {
    logic [CHAN_W-1:0]   chan;
    logic [BITSEL_W-1:0] bitpos;
    logic [LABEL_W-1:0]  label;
  } pin_cfg_t;
endpackage

// File: rtl/arxm_cfg_bank.sv
// Per-pin selector and label storage with read-back mux.
module arxm_cfg_bank
  import arxm_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output pin_cfg_t [NUM_PINS-1:0]       cfg_o,
  output logic [DATA_W-1:0]             rd_data_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] SEL_ADDR = CFG_BASE_ADDR + ADDR_W'(2 * p);
    localparam logic [ADDR_W-1:0] LAB_ADDR = SEL_ADDR + ADDR_W'(1);

    logic     wr_sel, wr_lab, cfg_en;
    pin_cfg_t cfg_d, cfg_q;

    assign wr_sel = reg_wr && (reg_addr == SEL_ADDR);
    assign wr_lab = reg_wr && (reg_addr == LAB_ADDR);
    assign cfg_en = wr_sel || wr_lab;

    always_comb begin
      cfg_d = cfg_q;
      if (wr_sel) begin
        cfg_d.chan   = reg_wdata[DATA_W-1 -: CHAN_W];
        cfg_d.bitpos = reg_wdata[BITSEL_W-1:0];
      end
      if (wr_lab) begin
        cfg_d.label = reg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_en) begin
        cfg_q <= cfg_d;
      end
    end

    assign cfg_o[p] = cfg_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (reg_addr == CFG_BASE_ADDR + ADDR_W'(2 * p)) begin
        rd_data_o = {cfg_o[p].chan, cfg_o[p].bitpos};
      end
      if (reg_addr == CFG_BASE_ADDR + ADDR_W'(2 * p + 1)) begin
        rd_data_o = cfg_o[p].label;
      end
    end
  end

endmodule

// File: rtl/arxm_pin_match.sv
// Decides whether the current received word addresses one pin.
module arxm_pin_match
  import arxm_pkg::*;
(
  input  pin_cfg_t           cfg_i,
  input  logic               rx_valid_i,
  input  logic               chan_en_i,
  input  logic [CHAN_W-1:0]  rx_chan_i,
  input  logic [WORD_W-1:0]  rx_word_i,
  output logic               hit_o,
  output logic               bit_o
);

  logic pos_ok, chan_ok, label_ok;

  assign pos_ok   = (cfg_i.bitpos >= BITSEL_W'(FIRST_MON_BIT));
  assign chan_ok  = chan_en_i && (rx_chan_i == cfg_i.chan);
  assign label_ok = (rx_word_i[LABEL_W-1:0] == cfg_i.label);

  assign hit_o = rx_valid_i && chan_ok && label_ok && pos_ok;
  assign bit_o = rx_word_i[cfg_i.bitpos];

endmodule

// File: rtl/arxm_pin_reg.sv
// Pin state: host preset first, monitored updates override per pin.
module arxm_pin_reg #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preset_wr_i,
  input  logic [NUM_PINS-1:0] preset_val_i,
  input  logic [NUM_PINS-1:0] upd_i,
  input  logic [NUM_PINS-1:0] upd_val_i,
  output logic [NUM_PINS-1:0] pins_o
);

  logic [NUM_PINS-1:0] pins_d, pins_q;
  logic                pins_en;

  assign pins_en = preset_wr_i || (|upd_i);

  always_comb begin
    pins_d = preset_wr_i ? preset_val_i : pins_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (upd_i[p]) begin
        pins_d[p] = upd_val_i[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
    end else if (pins_en) begin
      pins_q <= pins_d;
    end
  end

  assign pins_o = pins_q;

endmodule

// File: rtl/rx_bit_monitor.sv
// Top: received-word bit monitor. rst_n is expected to be released
// synchronously to clk by the surrounding reset tree.
module rx_bit_monitor
  import arxm_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CH   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   rx_en,
  input  logic                rx_valid,
  input  logic [CHAN_W-1:0]   rx_chan,
  input  logic [WORD_W-1:0]   rx_word,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] mon_pin
);

  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic [DATA_W-1:0]       cfg_rdata;
  logic [NUM_PINS-1:0]     hit, hit_val;
  logic                    chan_en;
  logic                    preset_wr;

  always_comb begin
    chan_en = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rx_chan == CHAN_W'(c)) begin
        chan_en = rx_en[c];
      end
    end
  end

  arxm_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cfg_o     (cfg),
    .rd_data_o (cfg_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_match
    arxm_pin_match u_match (
      .cfg_i      (cfg[p]),
      .rx_valid_i (rx_valid),
      .chan_en_i  (chan_en),
      .rx_chan_i  (rx_chan),
      .rx_word_i  (rx_word),
      .hit_o      (hit[p]),
      .bit_o      (hit_val[p])
    );
  end

  assign preset_wr = reg_wr && (reg_addr == STATUS_ADDR);

  arxm_pin_reg #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .preset_wr_i  (preset_wr),
    .preset_val_i (reg_wdata[NUM_PINS-1:0]),
    .upd_i        (hit),
    .upd_val_i    (hit_val),
    .pins_o       (mon_pin)
  );

  assign reg_rdata = (reg_addr == STATUS_ADDR) ? DATA_W'(mon_pin) : cfg_rdata;

endmodule

// File: rtl/rx_bit_monitor_chk.sv
// Port-level checker, bound to every rx_bit_monitor instance.
module rx_bit_monitor_chk
  import arxm_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CH   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   rx_en,
  input logic                rx_valid,
  input logic [CHAN_W-1:0]   rx_chan,
  input logic [WORD_W-1:0]   rx_word,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_PINS-1:0] mon_pin
);

  localparam logic [ADDR_W-1:0] DEAD_LO = CFG_BASE_ADDR + ADDR_W'(2 * NUM_PINS);
  localparam logic [ADDR_W-1:0] MAP_HI  = CFG_BASE_ADDR + ADDR_W'(2 * MAX_PINS - 1);

  logic src_on, preset;
  assign src_on = |(rx_en & (NUM_CH'(1) << rx_chan));
  assign preset = reg_wr && (reg_addr == STATUS_ADDR);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (mon_pin == '0));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !reg_wr) |=> $stable(mon_pin));

  a_r4_disabled_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !src_on && !preset) |=> $stable(mon_pin));

  a_r7_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (preset && !rx_valid) |=> (mon_pin == $past(reg_wdata[NUM_PINS-1:0])));

  a_r7_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STATUS_ADDR) |-> (reg_rdata == DATA_W'(mon_pin)));

  a_r10_dead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= DEAD_LO && reg_addr <= MAP_HI) |-> (reg_rdata == '0));

endmodule

bind rx_bit_monitor rx_bit_monitor_chk #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .rx_valid  (rx_valid),
  .rx_chan   (rx_chan),
  .rx_word   (rx_word),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .mon_pin   (mon_pin)
);

// File: tb/rx_bit_monitor_tb_top.sv
`timescale 1ns/1ps
module rx_bit_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_en;
  logic        rx_valid;
  logic [2:0]  rx_chan;
  logic [31:0] rx_word;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  rdata_f, rdata_r;
  logic [7:0]  pins_f;
  logic [1:0]  pins_r;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_bit_monitor #(.NUM_PINS(8), .NUM_CH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_chan(rx_chan), .rx_word(rx_word), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_f),
    .mon_pin(pins_f)
  );

  rx_bit_monitor #(.NUM_PINS(2), .NUM_CH(8)) dut_r_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_chan(rx_chan), .rx_word(rx_word), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_r),
    .mon_pin(pins_r)
  );

  // ---------------- behavioural reference ----------------
  int   m_ch  [8];
  int   m_pos [8];
  int   m_lab [8];
  logic [7:0] m_pins;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 8; p++) begin
        m_ch[p] = 0; m_pos[p] = 0; m_lab[p] = 0;
      end
      m_pins = 8'h00;
    end else begin
      logic [7:0] nxt;
      nxt = m_pins;
      if (reg_wr && reg_addr == 16'h805F) nxt = reg_wdata;
      if (rx_valid && rx_en[rx_chan]) begin
        for (int p = 0; p < 8; p++) begin
          if (m_ch[p] == int'(rx_chan) && m_lab[p] == int'(rx_word[7:0]) && m_pos[p] >= 8)
            nxt[p] = rx_word[m_pos[p]];
        end
      end
      if (reg_wr && reg_addr >= 16'h8060 && reg_addr <= 16'h806F) begin
        int idx;
        idx = int'(reg_addr - 16'h8060) / 2;
        if (reg_addr[0] == 1'b0) begin
          m_ch[idx]  = int'(reg_wdata[7:5]);
          m_pos[idx] = int'(reg_wdata[4:0]);
        end else begin
          m_lab[idx] = int'(reg_wdata);
        end
      end
      m_pins = nxt;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input int npins);
    logic [7:0] v;
    v = 8'h00;
    if (a == 16'h805F) begin
      v = (npins == 8) ? m_pins : {6'b0, m_pins[1:0]};
    end else if (a >= 16'h8060 && a < 16'h8060 + 16'(2 * npins)) begin
      int idx;
      idx = int'(a - 16'h8060) / 2;
      if (a[0] == 1'b0) v = {3'(m_ch[idx]), 5'(m_pos[idx])};
      else              v = 8'(m_lab[idx]);
    end
    return v;
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of both builds against the reference
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check8(pins_f, m_pins, "R2 cycle model, full pins");
      check8({6'b0, pins_r}, {6'b0, m_pins[1:0]}, "R2 cycle model, reduced pins");
      check8(rdata_f, exp_rd(reg_addr, 8), "R9 cycle model, full read");
      check8(rdata_r, exp_rd(reg_addr, 2), "R10 cycle model, reduced read");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
    reg_wr   = 1'b0;
    rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
  endtask

  task automatic rx(input logic [2:0] ch, input logic [31:0] w);
    rx_chan = ch; rx_word = w; rx_valid = 1'b1;
    step();
  endtask

  task automatic wr_rx(input logic [7:0] d, input logic [2:0] ch, input logic [31:0] w);
    reg_addr = 16'h805F; reg_wdata = d; reg_wr = 1'b1;
    rx_chan = ch; rx_word = w; rx_valid = 1'b1;
    step();
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] ef, input logic [7:0] er, input string tag);
    reg_addr = a;
    #1;
    check8(rdata_f, ef, {tag, " full"});
    check8(rdata_r, er, {tag, " reduced"});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 1'b0; rx_en = 8'h00; rx_valid = 1'b0; rx_chan = 3'd0;
    rx_word = '0; reg_addr = 16'h0000; reg_wr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check8(pins_f, 8'h00, "R1 pins in reset");
    rd(16'h805F, 8'h00, 8'h00, "R1 status in reset");
    rd(16'h8060, 8'h00, 8'h00, "R1 selector in reset");
    rd(16'h8061, 8'h00, 8'h00, "R1 label in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    rx_en = 8'hFF;
    step();

    // R9: pin0 channel 2, bit 10, label 0x31
    wr(16'h8060, 8'h4A);
    wr(16'h8061, 8'h31);
    rd(16'h8060, 8'h4A, 8'h4A, "R9 selector readback");
    rd(16'h8061, 8'h31, 8'h31, "R9 label readback");
    wr(16'h806E, 8'hE9);
    wr(16'h806F, 8'h7C);
    rd(16'h806E, 8'hE9, 8'h00, "R9 pin7 selector readback / R10 dead");
    rd(16'h806F, 8'h7C, 8'h00, "R9 pin7 label readback / R10 dead");

    // R2: bit 10 copied and held
    rx(3'd2, 32'h0000_0431);
    check8(pins_f, 8'h01, "R2 pin0 set from bit 10");
    rx(3'd2, 32'h0000_0031);
    check8(pins_f, 8'h00, "R2 pin0 cleared from bit 10");
    rx(3'd2, 32'h0000_0431);
    repeat (3) step();
    check8(pins_f, 8'h01, "R2 pin0 held while idle");

    // R5: reversed label, other label, other channel
    rx(3'd2, 32'h0000_008C);
    check8(pins_f, 8'h01, "R5 bit-reversed label ignored");
    rx(3'd2, 32'h0000_0030);
    check8(pins_f, 8'h01, "R5 different label ignored");
    rx(3'd3, 32'h0000_0031);
    check8(pins_f, 8'h01, "R5 different channel ignored");

    // R4: disabled channel
    rx_en = 8'hFB;
    rx(3'd2, 32'h0000_0031);
    check8(pins_f, 8'h01, "R4 disabled channel ignored");
    rx_en = 8'hFF;

    // R3: pin1 selects bit 5 (set in label 0x31) -> no effect
    wr(16'h8062, 8'h45);
    wr(16'h8063, 8'h31);
    rx(3'd2, 32'h0000_0031);
    check8(pins_f, 8'h00, "R3 low bit position ignored, pin0 cleared");

    // R6: pin1 selects bit 31, one word updates both
    wr(16'h8062, 8'h5F);
    rx(3'd2, 32'h8000_0431);
    check8(pins_f, 8'h03, "R6 two pins same cycle");
    check8({6'b0, pins_r}, 8'h03, "R6 two pins same cycle, reduced");

    // R7: preset and mirror
    wr(16'h805F, 8'hF0);
    check8(pins_f, 8'hF0, "R7 preset loads pins");
    rd(16'h805F, 8'hF0, 8'h00, "R7 status mirror / R10 upper bits zero");
    wr(16'h805F, 8'h03);
    rd(16'h805F, 8'h03, 8'h03, "R7 status mirror after second preset");

    // R8: word beats preset on the same pin
    wr_rx(8'h00, 3'd2, 32'h8000_0431);
    check8(pins_f, 8'h03, "R8 update wins over preset 0x00");
    wr_rx(8'hFF, 3'd2, 32'h0000_0031);
    check8(pins_f, 8'hFC, "R8 update wins over preset 0xFF");
    check8({6'b0, pins_r}, 8'h00, "R8 reduced pins");

    // R10: dead pin addresses in the reduced build
    wr(16'h8064, 8'h4A);
    wr(16'h8065, 8'h31);
    rd(16'h8064, 8'h4A, 8'h00, "R10 pin2 selector");
    rd(16'h8065, 8'h31, 8'h00, "R10 pin2 label");
    rd(16'h9000, 8'h00, 8'h00, "R10 unmapped address");
    rx(3'd2, 32'h0000_0431);
    check8(pins_f, 8'hFD, "R10 full build pin2 follows bit 10");
    check8({6'b0, pins_r}, 8'h01, "R10 reduced build unaffected");
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule